// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the column address for each beat of an SDRAM read or write burst. A request carries a start column, a burst length of four or eight beats, and an ordering choice. The block accepts it on a one-cycle start strobe while idle. From the next clock edge on, it presents one column address per cycle, each with a valid flag. A last flag marks the final beat.

The burst stays inside an aligned window the size of the burst length. Only the low column bits inside that window move. Every column bit above the window is copied from the start column. In sequential order the offset counts up from the start offset and wraps around within the window. In interleaved order the offset is the start offset XORed with the beat number. A busy output covers the whole burst, and any start strobe that arrives while busy is high is dropped.

Top module: `sdram_burst_colgen`

## Requirements
- R1: With burst length 4 (`len8_i` = 0), only column bits [1:0] differ between beats; column bit 2 and everything above it equal the start column on every beat.
- R2: With burst length 8 (`len8_i` = 1), only column bits [2:0] differ between beats; bits above bit 2 equal the start column on every beat.
- R3: Sequential order (`interleave_i` = 0): the window offset on beat i equals (start offset + i) modulo the burst length, e.g. start offset 2 with length 4 gives 2,3,0,1.
- R4: Interleaved order (`interleave_i` = 1): the window offset on beat i equals the start offset XOR i, e.g. start offset 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: An accepted burst produces exactly burst-length consecutive cycles with `valid_o` high, and every offset of the window appears exactly once among them.
- R6: `last_o` is high only on the final beat of a burst, together with the final address and with `valid_o` high.
- R7: `valid_o` is low in the cycle after the last beat unless a new burst was accepted; `busy_o` is high on every beat of a burst, from the first through the last.
- R8: The first address of a burst appears on the first clock edge after the edge that samples `start_i` high while `busy_o` is low.
- R9: `start_i` sampled while `busy_o` is high is ignored: the address sequence, length and order of the running burst are unaffected, and no extra burst follows it.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `valid_o`, `last_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle burst request strobe |
| start_col_i | input | COL_W | Start column address |
| len8_i | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| interleave_i | input | 1 | Ordering select: 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a burst address this cycle |
| last_o | output | 1 | Current beat is the final one of the burst |
| busy_o | output | 1 | A burst is in progress; new starts are ignored |

## Verification
The assertions take for granted that the start column, length and order inputs matter only in the cycle in which a start is accepted. For that reason the upper-bit and ordering checks compare beats against the captured request, not against the live inputs. They also assume that `start_i` is a clean synchronous level. The stimulus drives every input on the falling edge and samples the outputs on the next falling edge. It raises `start_i` only for one cycle at a time, except in the cases that deliberately hit it while busy, including on the last beat. It changes the other request inputs during a burst only to show that they have no effect.

// File: rtl/sdram_burst_pkg.sv
// Package: shared types for the burst column address generator.
// Assumes: burst windows of at most eight beats (three offset bits).
package sdram_burst_pkg;
    localparam int OFF_W = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic               len8;
        burst_order_e       order;
        logic [OFF_W-1:0]   start_off;
    } burst_cfg_t;
endpackage

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Counts the beats of one burst. It raises active on the edge after an
// accepted start and drops it after the final beat.
// Assumes: len8 is stable while active (held in a register by the parent).
module burst_beat_ctr
    import sdram_burst_pkg::*;
#(
    parameter int BEAT_W = OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              len8,
    output logic              active,
    output logic [BEAT_W-1:0] beat,
    output logic              final_beat
);
    localparam logic [BEAT_W-1:0] LAST4 = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] LAST8 = BEAT_W'(7);

    logic [BEAT_W-1:0] last_idx;

    // Index of the final beat for the selected length.
    always_comb last_idx = len8 ? LAST8 : LAST4;

    // Final beat: active and the counter has reached the final index.
    always_comb final_beat = active && (beat == last_idx);

    // Beat counter and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (take) begin
            active <= 1'b1;
            beat   <= '0;
        end else if (active) begin
            if (final_beat) begin
                active <= 1'b0;
                beat   <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (beat <= last_idx)); // R5
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !final_beat && !take) |=> (active && beat == $past(beat) + 1'b1)); // R5
endmodule

// File: rtl/burst_offset_map.sv
// Module: burst_offset_map
// Maps a beat index to a window offset for sequential or interleaved order.
// Offset bits outside the window pass through from the start offset.
// Assumes: beat stays below the burst length.
module burst_offset_map
    import sdram_burst_pkg::*;
#(
    parameter int W = OFF_W
) (
    input  logic         len8,
    input  burst_order_e order,
    input  logic [W-1:0] start_off,
    input  logic [W-1:0] beat,
    output logic [W-1:0] off
);
    logic [W-1:0] seq_off;
    logic [W-1:0] ilv_off;
    logic [W-1:0] pick;

    // Both orderings; the carry out of the window is discarded by masking below.
    always_comb begin
        seq_off = start_off + beat;
        ilv_off = start_off ^ beat;
        pick    = (order == ORD_ILV) ? ilv_off : seq_off;
    end

    // Per-bit select: the two low bits always move, the top bit only for length 8.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b < W - 1) begin : g_always
            assign off[b] = pick[b];
        end else begin : g_len8
            assign off[b] = len8 ? pick[b] : start_off[b];
        end
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
// Module: sdram_burst_colgen (top)
// Captures a burst request and emits one column address per cycle.
// Upper bits come from the start column; low bits come from the offset map.
// Assumes: COL_W >= 4; start_i is synchronous to clk.
module sdram_burst_colgen
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             len8_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_o
);
    localparam int UP_W = COL_W - OFF_W;

    burst_cfg_t        cfg_q;
    logic [UP_W-1:0]   upper_q;
    logic              take;
    logic              active;
    logic              final_beat;
    logic [OFF_W-1:0]  beat;
    logic [OFF_W-1:0]  off;

    // Accept a start only while idle.
    always_comb take = start_i && !active;

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            upper_q <= '0;
        end else if (take) begin
            cfg_q.len8      <= len8_i;
            cfg_q.order     <= interleave_i ? ORD_ILV : ORD_SEQ;
            cfg_q.start_off <= start_col_i[OFF_W-1:0];
            upper_q         <= start_col_i[COL_W-1:OFF_W];
        end
    end

    burst_beat_ctr #(.BEAT_W(OFF_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .len8       (cfg_q.len8),
        .active     (active),
        .beat       (beat),
        .final_beat (final_beat)
    );

    burst_offset_map #(.W(OFF_W)) u_map (
        .len8      (cfg_q.len8),
        .order     (cfg_q.order),
        .start_off (cfg_q.start_off),
        .beat      (beat),
        .off       (off)
    );

    // Output assembly.
    always_comb begin
        col_o   = {upper_q, off};
        valid_o = active;
        busy_o  = active;
        last_o  = final_beat;
    end

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R6
    AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o); // R7
    AST_FIRST_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (valid_o && !$past(valid_o))); // R8
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(last_o))
            |-> (col_o[COL_W-1:OFF_W] == $past(col_o[COL_W-1:OFF_W]))); // R1
    AST_LEN4_BIT2_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(last_o) && !cfg_q.len8)
            |-> (col_o[OFF_W-1] == $past(col_o[OFF_W-1]))); // R1
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> (valid_o && $stable(cfg_q))); // R9
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             len8_i = 1'b0;
    logic             interleave_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, busy_o;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len8_i(len8_i), .interleave_i(interleave_i), .col_o(col_o),
        .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
            input logic l8, input logic ilv, input int i);
        int len = l8 ? 8 : 4;
        int so = int'(s) % len;
        int o = ilv ? (so ^ i) : ((so + i) % len);
        return COL_W'((int'(s) / len) * len + o);
    endfunction

    // Check the reset state (R10).
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 valid", valid_o, 0);
        check("R10 last", last_o, 0);
        check("R10 busy", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Run one burst and check every beat. If poke_beat >= 0, a conflicting
    // start is raised during that beat (R9).
    task automatic t_burst(input logic [COL_W-1:0] s, input logic l8,
            input logic ilv, input int poke_beat, input string tag);
        int len = l8 ? 8 : 4;
        logic [7:0] seen = '0;
        start_col_i = s; len8_i = l8; interleave_i = ilv; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < len; i++) begin
            // Sample beat i here (R8: beat 0 one edge after start).
            check({tag, " valid R5/R8"}, valid_o, 1);
            check({tag, " busy R7"}, busy_o, 1);
            check({tag, " col R1/R2/R3/R4"}, col_o, exp_col(s, l8, ilv, i));
            check({tag, " last R6"}, last_o, (i == len - 1));
            check({tag, " upper R1/R2"}, col_o >> (l8 ? 3 : 2), s >> (l8 ? 3 : 2));
            if (seen[col_o[2:0] % len]) check({tag, " repeat R5"}, 1, 0);
            seen[col_o[2:0] % len] = 1'b1;
            if (i == poke_beat) begin
                start_i = 1'b1; start_col_i = ~s; len8_i = ~l8; interleave_i = ~ilv;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        check({tag, " coverage R5"}, $countones(seen), len);
        check({tag, " valid low after last R7/R9"}, valid_o, 0);
        check({tag, " busy low after last R7"}, busy_o, 0);
        @(negedge clk);
        check({tag, " no extra burst R9"}, valid_o, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_burst(9'h1A6, 1'b0, 1'b0, -1, "R3 seq4 start2");
        t_burst(9'h0F5, 1'b1, 1'b1, -1, "R4 ilv8 start5");
        t_burst(9'h133, 1'b0, 1'b1, -1, "R4 ilv4 start3");
        t_burst(9'h0AE, 1'b1, 1'b0, -1, "R3 seq8 start6");
        t_burst(9'h1F8, 1'b1, 1'b0, -1, "R2 seq8 aligned");
        t_burst(9'h04D, 1'b0, 1'b0, 1, "R9 poke mid len4");
        t_burst(9'h162, 1'b1, 1'b1, 7, "R9 poke on last");
        t_burst(9'h1FF, 1'b0, 1'b1, 0, "R1 top col");
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule